// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps coherence state for a small direct-mapped write-back cache that sits on a shared snooping bus. Each line holds one data word, a tag and one of three states: Invalid, Shared (clean and read-only) or Exclusive (sole copy, writable, dirty). CPU reads and writes arrive on one side. Snooped read misses and write misses from other masters arrive on the other side. The controller answers hits at once. A miss goes through a request/grant handshake, and the controller then places write-back, read-miss or write-miss commands on the bus.

A write to a clean Shared copy is handled as a write miss, so other caches drop their copies. A snooped access that finds the local line dirty drives the block out and tells memory to abort its own reply. The controller changes no line before it owns the bus. While it waits for a grant, a snoop that changes the line it is waiting on makes it drop the request and decide again from the new line state.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, bus_req_o and cpu_done_o are low, and no snoop flushes.
- R2: A CPU read that misses issues a read miss (bus_cmd_o = 01) for the request address. It returns fill_data_i with cpu_done_o in the cycle the fill arrives, and leaves the line Shared.
- R3: A CPU write that misses a non-dirty line issues a write miss (bus_cmd_o = 10) and leaves the line Exclusive with the written word.
- R4: A CPU write to a Shared line with a matching tag issues a write miss with no write-back and leaves the line Exclusive.
- R5: A CPU miss whose index holds an Exclusive line with another tag first issues a write-back (bus_cmd_o = 11) of the old tag, index and word. The new miss follows in the next cycle.
- R6: A snooped write miss (snp_wr_i = 1) that matches a Shared line invalidates it without a flush. A snooped read miss leaves a Shared line unchanged.
- R7: A snooped write miss that matches an Exclusive line raises snp_flush_o and snp_abort_o in the same cycle with the line's word on snp_data_o, and leaves the line Invalid.
- R8: A snooped read miss that matches an Exclusive line raises snp_flush_o and snp_abort_o with the line's word, and leaves the line Shared.
- R9: bus_cmd_o is non-zero only while bus_gnt_i is high, and no line changes for a miss before the grant.
- R10: A snoop that changes the pending line while the controller waits for a grant makes it drop the request and re-evaluate. A write-back that is no longer needed is not issued.
- R11: CPU read hits in Shared or Exclusive and write hits in Exclusive raise cpu_done_o in the cycle of the request with no bus request.
- R12: When a snoop and an idle-time CPU request arrive in the same cycle, the snoop is served and cpu_done_o stays low that cycle.
- R13: A snoop whose tag does not match, or that finds the line Invalid, causes no flush and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU request, held until cpu_done_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: tag above, index in the low bits |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_done_o | output | 1 | Request completes at this clock edge |
| cpu_rdata_o | output | DATA_W | Read word, valid with cpu_done_o |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus grant, held while bus_req_o is high |
| bus_cmd_o | output | 2 | 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Address of the bus command |
| bus_data_o | output | DATA_W | Write-back word |
| fill_valid_i | input | 1 | Fill word present for the outstanding miss |
| fill_data_i | input | DATA_W | Fill word |
| snp_valid_i | input | 1 | Snooped transaction present this cycle |
| snp_wr_i | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_flush_o | output | 1 | Local dirty copy is driven out |
| snp_abort_o | output | 1 | Memory must abort its reply |
| snp_data_o | output | DATA_W | Flushed word |

## Verification
Directed sequences walk each line through every state-and-event pair: read and write misses from Invalid, the write upgrade from Shared, dirty eviction, and both snoop kinds against Shared and Exclusive lines. Each sequence is followed by a CPU access whose bus traffic shows which state the line was left in. Two timing cases are also driven: a snoop arriving together with a CPU hit, and a snoop that cleans the victim while the controller waits on a held-off grant. In the second case the absence of a write-back separates a true restart from a stale decision. Random mixes over four tags that share eight indices, with varying grant and fill delays, produce frequent conflicts. The observed commands, addresses, write-back words, flush outputs and read data are compared with a bench-side line and memory model.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_E = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_RDMISS = 2'd1,
    CMD_WRMISS = 2'd2,
    CMD_WB     = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_ARB,
    F_WB,
    F_MISS,
    F_FILL
  } fsm_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output line_st_e          cpu_st_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  input  logic [IDX_W-1:0]  snp_idx_i,
  output line_st_e          snp_st_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  line_st_e          wr_st_i,
  input  logic              wr_full_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LINE_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      st_q[wr_idx_i] <= wr_st_i;
      if (wr_full_i) begin
        tag_q[wr_idx_i]  <= wr_tag_i;
        data_q[wr_idx_i] <= wr_data_i;
      end
    end
  end

  assign cpu_st_o   = st_q[cpu_idx_i];
  assign cpu_tag_o  = tag_q[cpu_idx_i];
  assign cpu_data_o = data_q[cpu_idx_i];
  assign snp_st_o   = st_q[snp_idx_i];
  assign snp_tag_o  = tag_q[snp_idx_i];
  assign snp_data_o = data_q[snp_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid_i,
  input  logic              snp_wr_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              upd_o,
  output line_st_e          upd_st_o,
  output logic              flush_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] flush_data_o
);
  logic hit, dirty;

  assign hit   = snp_valid_i && (line_st_i != LINE_I) && (line_tag_i == snp_tag_i);
  assign dirty = hit && (line_st_i == LINE_E);

  // Shared + read miss keeps the line; everything else that hits downgrades it.
  assign upd_o        = hit && (snp_wr_i || dirty);
  assign upd_st_o     = snp_wr_i ? LINE_I : LINE_S;
  assign flush_o      = dirty;
  assign abort_o      = dirty;
  assign flush_data_o = line_data_i;
endmodule

// File: rtl/msi_miss_fsm.sv
module msi_miss_fsm
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  parameter int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  input  logic [TAG_W-1:0]  cpu_tag_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [IDX_W-1:0]  look_idx_o,
  input  line_st_e          line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              snp_busy_i,
  input  logic              snp_upd_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              bus_gnt_i,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output line_st_e          wr_st_o,
  output logic              wr_full_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic [DATA_W-1:0] wr_data_o
);
  fsm_e              st_q, st_d;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, wb_q;

  logic [TAG_W-1:0] cur_tag;
  logic tag_eq, valid_hit, excl_hit, accept;

  assign look_idx_o = (st_q == F_IDLE) ? cpu_idx_i : idx_q;
  assign cur_tag    = (st_q == F_IDLE) ? cpu_tag_i : tag_q;
  assign tag_eq     = (line_tag_i == cur_tag);
  assign valid_hit  = (line_st_i != LINE_I) && tag_eq;
  assign excl_hit   = (line_st_i == LINE_E) && tag_eq;
  assign accept     = (st_q == F_IDLE) && cpu_req_i && !snp_busy_i &&
                      !(cpu_we_i ? excl_hit : valid_hit);

  always_comb begin
    st_d        = st_q;
    cpu_done_o  = 1'b0;
    cpu_rdata_o = '0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = CMD_NONE;
    bus_addr_o  = '0;
    bus_data_o  = '0;
    wr_en_o     = 1'b0;
    wr_idx_o    = look_idx_o;
    wr_st_o     = LINE_I;
    wr_full_o   = 1'b0;
    wr_tag_o    = cur_tag;
    wr_data_o   = '0;
    unique case (st_q)
      F_IDLE: begin
        if (cpu_req_i && !snp_busy_i) begin
          if (cpu_we_i ? excl_hit : valid_hit) begin
            cpu_done_o  = 1'b1;
            cpu_rdata_o = line_data_i;
            if (cpu_we_i) begin
              wr_en_o   = 1'b1;
              wr_full_o = 1'b1;
              wr_st_o   = LINE_E;
              wr_data_o = cpu_wdata_i;
            end
          end else begin
            st_d = F_ARB;
          end
        end
      end
      F_ARB: begin
        bus_req_o = 1'b1;
        // a snoop that touched the pending line invalidates the earlier decision
        if (snp_upd_i && snp_idx_i == idx_q) st_d = F_IDLE;
        else if (bus_gnt_i)                  st_d = wb_q ? F_WB : F_MISS;
      end
      F_WB: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = CMD_WB;
        bus_addr_o = {line_tag_i, idx_q};
        bus_data_o = line_data_i;
        st_d       = F_MISS;
      end
      F_MISS: begin
        bus_req_o  = 1'b1;
        bus_cmd_o  = we_q ? CMD_WRMISS : CMD_RDMISS;
        bus_addr_o = {tag_q, idx_q};
        st_d       = F_FILL;
      end
      F_FILL: begin
        bus_req_o = 1'b1;
        if (fill_valid_i) begin
          cpu_done_o  = 1'b1;
          cpu_rdata_o = we_q ? wdata_q : fill_data_i;
          wr_en_o     = 1'b1;
          wr_full_o   = 1'b1;
          wr_st_o     = we_q ? LINE_E : LINE_S;
          wr_data_o   = we_q ? wdata_q : fill_data_i;
          st_d        = F_IDLE;
        end
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      idx_q   <= '0;
      tag_q   <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        idx_q   <= cpu_idx_i;
        tag_q   <= cpu_tag_i;
        wdata_q <= cpu_wdata_i;
        we_q    <= cpu_we_i;
        wb_q    <= (line_st_i == LINE_E) && !tag_eq;
      end
    end
  end

  p_cmd_gnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != CMD_NONE) |-> bus_gnt_i);

  p_wb_then_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == CMD_WB) |=> (bus_cmd_o == CMD_RDMISS || bus_cmd_o == CMD_WRMISS));

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_ARB && snp_upd_i && snp_idx_i == idx_q) |=> (st_q == F_IDLE && !bus_req_o));

  p_fill_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_FILL && fill_valid_i) |=> !bus_req_o);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              snp_valid_i,
  input  logic              snp_wr_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_flush_o,
  output logic              snp_abort_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx, snp_idx, fsm_wr_idx, wr_idx;
  logic [TAG_W-1:0]  snp_tag, cpu_line_tag, snp_line_tag, fsm_wr_tag;
  logic [DATA_W-1:0] cpu_line_data, snp_line_data, fsm_wr_data;
  line_st_e          cpu_line_st, snp_line_st, snp_upd_st, fsm_wr_st, wr_st;
  logic              snp_upd, fsm_wr_en, fsm_wr_full, wr_en, wr_full;
  bus_cmd_e          cmd;

  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  // snoop updates win the single write port
  assign wr_en   = snp_upd || fsm_wr_en;
  assign wr_idx  = snp_upd ? snp_idx : fsm_wr_idx;
  assign wr_st   = snp_upd ? snp_upd_st : fsm_wr_st;
  assign wr_full = !snp_upd && fsm_wr_full;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_idx_i  (look_idx),
    .cpu_st_o   (cpu_line_st),
    .cpu_tag_o  (cpu_line_tag),
    .cpu_data_o (cpu_line_data),
    .snp_idx_i  (snp_idx),
    .snp_st_o   (snp_line_st),
    .snp_tag_o  (snp_line_tag),
    .snp_data_o (snp_line_data),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_st_i    (wr_st),
    .wr_full_i  (wr_full),
    .wr_tag_i   (fsm_wr_tag),
    .wr_data_i  (fsm_wr_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_wr_i     (snp_wr_i),
    .snp_tag_i    (snp_tag),
    .line_st_i    (snp_line_st),
    .line_tag_i   (snp_line_tag),
    .line_data_i  (snp_line_data),
    .upd_o        (snp_upd),
    .upd_st_o     (snp_upd_st),
    .flush_o      (snp_flush_o),
    .abort_o      (snp_abort_o),
    .flush_data_o (snp_data_o)
  );

  msi_miss_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_idx_i    (cpu_addr_i[IDX_W-1:0]),
    .cpu_tag_i    (cpu_addr_i[ADDR_W-1:IDX_W]),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .look_idx_o   (look_idx),
    .line_st_i    (cpu_line_st),
    .line_tag_i   (cpu_line_tag),
    .line_data_i  (cpu_line_data),
    .snp_busy_i   (snp_valid_i),
    .snp_upd_i    (snp_upd),
    .snp_idx_i    (snp_idx),
    .bus_gnt_i    (bus_gnt_i),
    .fill_valid_i (fill_valid_i),
    .fill_data_i  (fill_data_i),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (cmd),
    .bus_addr_o   (bus_addr_o),
    .bus_data_o   (bus_data_o),
    .wr_en_o      (fsm_wr_en),
    .wr_idx_o     (fsm_wr_idx),
    .wr_st_o      (fsm_wr_st),
    .wr_full_o    (fsm_wr_full),
    .wr_tag_o     (fsm_wr_tag),
    .wr_data_o    (fsm_wr_data)
  );

  assign bus_cmd_o = cmd;

  p_snoop_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && !bus_req_o) |-> !cpu_done_o);

  p_flush_dirty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_flush_o && !snp_wr_i) |=> (snp_line_st == LINE_S || $past(snp_idx) != snp_idx));
endmodule

// File: tb/msi_snoop_ctrl_test.sv
module msi_snoop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        bus_req, bus_gnt = 0;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_data;
  logic        fill_valid = 0;
  logic [31:0] fill_data = '0;
  logic        snp_valid = 0, snp_wr = 0;
  logic [15:0] snp_addr = '0;
  logic        snp_flush, snp_abort;
  logic [31:0] snp_data;

  int n_chk = 0, n_fail = 0, nogrant_cmds = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_snoop_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .snp_valid_i(snp_valid), .snp_wr_i(snp_wr), .snp_addr_i(snp_addr),
    .snp_flush_o(snp_flush), .snp_abort_o(snp_abort), .snp_data_o(snp_data)
  );

  // reference model: line states 0=I 1=S 2=E, plus backing memory
  int          m_st [8];
  logic [12:0] m_tag [8];
  logic [31:0] m_data [8];
  logic [31:0] mem [int];

  typedef struct packed { logic [1:0] cmd; logic [15:0] addr; logic [31:0] data; } ent_t;
  ent_t blog[$];

  int  gnt_delay = 0, fill_lat = 0;
  bit  arb_hold = 0;

  function automatic logic [31:0] mem_rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {16'hC0DE, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus agent: arbiter, memory, fill return, command log
  initial begin : bus_agent
    int  wcnt = 0, fcnt = 0;
    bit  pend = 0;
    logic [15:0] paddr = '0;
    forever begin
      @(negedge clk);
      fill_valid = 0;
      if (pend) begin
        if (fcnt == 0) begin
          fill_valid = 1;
          fill_data  = mem_rd(paddr);
          pend = 0;
        end else fcnt--;
      end
      if (bus_cmd != C_NONE) begin
        if (!bus_gnt) nogrant_cmds++;
        blog.push_back('{bus_cmd, bus_addr, bus_data});
        if (bus_cmd == C_WB) mem[int'(bus_addr)] = bus_data;
        else begin pend = 1; fcnt = fill_lat; paddr = bus_addr; end
      end
      if (!bus_req) begin bus_gnt = 0; wcnt = 0; end
      else if (!bus_gnt) begin
        if (!arb_hold && wcnt >= gnt_delay) bus_gnt = 1;
        else wcnt++;
      end
    end
  end

  task automatic check_log(input string req, input ent_t exp[$]);
    chk(req, "bus command count", 64'(blog.size()), 64'(exp.size()));
    if (blog.size() == exp.size())
      foreach (exp[i]) begin
        chk(req, "bus cmd", 64'(blog[i].cmd), 64'(exp[i].cmd));
        chk(req, "bus addr", 64'(blog[i].addr), 64'(exp[i].addr));
        if (exp[i].cmd == C_WB) chk(req, "write-back word", 64'(blog[i].data), 64'(exp[i].data));
      end
  endtask

  task automatic cpu_op(input bit we, input logic [15:0] addr, input logic [31:0] wd);
    int idx = int'(addr[2:0]);
    logic [12:0] tg = addr[15:3];
    bit hit = we ? (m_st[idx] == 2 && m_tag[idx] == tg) : (m_st[idx] != 0 && m_tag[idx] == tg);
    bit wb  = !hit && m_st[idx] == 2 && m_tag[idx] != tg;
    string rq = hit ? "R11" : wb ? "R5" : (we && m_st[idx] == 1 && m_tag[idx] == tg) ? "R4" : we ? "R3" : "R2";
    ent_t exp[$];
    logic [31:0] exp_rd;
    int waits = 0;
    if (wb) begin
      exp.push_back('{C_WB, {m_tag[idx], addr[2:0]}, m_data[idx]});
      mem[int'({m_tag[idx], addr[2:0]})] = m_data[idx];
    end
    if (!hit) exp.push_back('{we ? C_WR : C_RD, addr, 32'h0});
    exp_rd = hit ? m_data[idx] : mem_rd(addr);
    if (we) begin m_st[idx] = 2; m_data[idx] = wd; end
    else begin if (!hit) m_st[idx] = 1; m_data[idx] = exp_rd; end
    m_tag[idx] = tg;
    blog.delete();
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    while (!cpu_done) begin @(negedge clk); #1; waits++; end
    if (!we) chk(rq, "read data", 64'(cpu_rdata), 64'(exp_rd));
    if (hit) chk("R11", "hit wait cycles", 64'(waits), 64'd0);
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    repeat (2) @(negedge clk);
    check_log(rq, exp);
  endtask

  task automatic snoop_op(input bit wr, input logic [15:0] addr);
    int idx = int'(addr[2:0]);
    bit hit = m_st[idx] != 0 && m_tag[idx] == addr[15:3];
    bit dirty = hit && m_st[idx] == 2;
    string rq = dirty ? (wr ? "R7" : "R8") : (hit ? "R6" : "R13");
    @(negedge clk);
    snp_valid = 1; snp_wr = wr; snp_addr = addr;
    #1;
    chk(rq, "flush", 64'(snp_flush), 64'(dirty));
    chk(rq, "abort", 64'(snp_abort), 64'(dirty));
    if (dirty) begin
      chk(rq, "flush word", 64'(snp_data), 64'(m_data[idx]));
      mem[int'(addr)] = m_data[idx];
    end
    if (hit && (wr || dirty)) m_st[idx] = wr ? 0 : 1;
    if (wr) mem[int'(addr)] = $urandom;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic finish_run();
    chk("R9", "commands without grant", 64'(nogrant_cmds), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    ent_t exp[$];
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "bus_req after reset", 64'(bus_req), 64'd0);
    chk("R1", "done after reset", 64'(cpu_done), 64'd0);
    for (int i = 0; i < 8; i++) snoop_op(1'b0, {13'd0, 3'(i)});   // R1: nothing flushes

    // R2 / R11 / R4 / R3
    cpu_op(0, 16'h0011, '0);
    cpu_op(0, 16'h0011, '0);
    cpu_op(1, 16'h0011, 32'h1111_0001);
    cpu_op(1, 16'h0011, 32'h1111_0002);
    cpu_op(0, 16'h0011, '0);
    cpu_op(1, 16'h0022, 32'h2222_0001);
    // R5: dirty victim on both read and write misses
    cpu_op(0, 16'h0122, '0);
    cpu_op(1, 16'h0019, 32'h3333_0001);
    cpu_op(1, 16'h0021, 32'h3333_0002);
    // R8 then hit and upgrade
    snoop_op(0, 16'h0021);
    cpu_op(0, 16'h0021, '0);
    cpu_op(1, 16'h0021, 32'h4444_0001);
    // R7 then miss
    snoop_op(1, 16'h0021);
    cpu_op(0, 16'h0021, '0);
    // R6: read snoop keeps Shared, write snoop invalidates
    snoop_op(0, 16'h0021);
    cpu_op(0, 16'h0021, '0);
    snoop_op(1, 16'h0021);
    cpu_op(0, 16'h0021, '0);
    // R13: other tag, Invalid line
    snoop_op(1, 16'h0121);
    snoop_op(1, 16'h0007);
    cpu_op(0, 16'h0021, '0);

    // R12: snoop and CPU hit in the same cycle
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 16'h0021;
    snp_valid = 1; snp_wr = 0; snp_addr = 16'h0006;
    #1;
    chk("R12", "done under snoop", 64'(cpu_done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R12", "done after snoop", 64'(cpu_done), 64'd1);
    chk("R12", "read data", 64'(cpu_rdata), 64'(m_data[1]));
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;

    // R10: victim cleaned by a snoop while waiting for grant
    cpu_op(1, 16'h002D, 32'h5555_0001);           // idx 5, tag 5 -> Exclusive
    arb_hold = 1;
    blog.delete();
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 16'h004D;  // idx 5, tag 9
    while (!bus_req) @(negedge clk);
    snoop_op(0, 16'h002D);                         // R10: flushes, line -> Shared
    repeat (2) @(negedge clk);
    chk("R10", "no command while grant held off", 64'(blog.size()), 64'd0);
    arb_hold = 0;
    #1;
    while (!cpu_done) begin @(negedge clk); #1; end
    chk("R10", "read data after restart", 64'(cpu_rdata), 64'(mem_rd(16'h004D)));
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    repeat (2) @(negedge clk);
    exp.push_back('{C_RD, 16'h004D, 32'h0});
    check_log("R10", exp);
    m_st[5] = 1; m_tag[5] = 13'd9; m_data[5] = mem_rd(16'h004D);

    // random mix over four tags sharing eight indices
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a = {13'($urandom % 4), 3'($urandom % 8)};
      int k = int'($urandom % 5);
      gnt_delay = int'($urandom % 3);
      fill_lat  = int'($urandom % 3);
      case (k)
        0, 1: cpu_op(0, a, '0);
        2:    cpu_op(1, a, $urandom);
        3:    snoop_op(0, a);
        default: snoop_op(1, a);
      endcase
    end
    finish_run();
  end
endmodule